// File: doc/BRIEF.md
# Masked-Input General-Purpose I/O Port

This block is one 8-bit general-purpose I/O port with a small register bus. Each pin has an output latch bit, a direction bit and an analog-select bit. The port as a whole has one slew-select bit. The latch drives the pad output data. A cleared direction bit turns on that pin's output driver. The slew bit goes straight to the pads as a rate-select signal. Pad inputs pass through a synchronizer. Any pin whose analog-select bit is set then reads as zero through the port address.

Software writes the port address or the latch address, and both land in the same output latch. Reading the port address returns the live, masked pin levels. Reading the latch address returns what was last written. Because of this, a read-modify-write done through the port address copies zeros from analog-selected pins back into the latch. This clears any such pin that was driving a 1. Out of reset every pin is an analog input with its driver off and the reduced slew rate selected.

Top module: `gpio_amask_port`

## Requirements
- R1: After reset the latch reads 0x00, the direction register reads 0xFF, the analog-select register reads 0xFF and the slew register reads 0x01. `pad_oe` is 0, `pad_out` is 0 and `pad_slow` is 1.
- R2: A read of address 0 (port) returns the synchronized pad level for each pin. A pin whose analog-select bit is 1 returns 0.
- R3: A change on `pad_in` shows up in a port read after exactly two rising clock edges, and not after one.
- R4: A write to address 0 or to address 1 stores `bus_wdata` into the output latch. A read of address 1 then returns that value.
- R5: A read of address 1 returns the latch contents whatever the pad levels and the analog-select bits are.
- R6: `pad_out` always equals the latch. Writing the analog-select register (address 3) leaves `pad_out` unchanged. `pad_oe` is the bitwise inverse of the direction register (address 2), where 1 means input.
- R7: Writes to address 2 (direction) and address 3 (analog select) take effect on the next edge and read back unchanged.
- R8: Address 4 holds the slew bit in bit 0, where 1 means reduced rate. `pad_slow` follows it, and bits 7:1 of a read of address 4 are 0.
- R9: Addresses 5 to 7 read as 0. Writes to them change no register and no pad output.
- R10: A read-modify-write through the port address, on output pins with analog select set and latch bits at 1, clears those latch bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on / brown-out) |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output data |
| pad_oe | output | 8 | Pad output enable, 1 = driving |
| pad_slow | output | 1 | Reduced slew-rate select |

## Verification
The port read is driven with several pad patterns (0xA5, 0x5A and walking ones) under analog-select masks of all-ones, all-zeros and split nibbles. This separates a mask applied to the wrong bits or with the wrong polarity from a correct one. A pad change is timed edge by edge so that a synchronizer that is one stage short or one stage long is caught. The latch address is read while the pads and masks move, which tells a latch readback apart from a pin readback. The read-modify-write sequence on mixed analog and digital output pins confirms that the port and latch addresses share one register.

// File: rtl/gpio_amask_pkg.sv
package gpio_amask_pkg;
   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_PORT  = 3'd0,
      REG_LATCH = 3'd1,
      REG_DIR   = 3'd2,
      REG_ANSEL = 3'd3,
      REG_SLEW  = 3'd4
   } port_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= '0;
      else        stg_q[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[s] <= '0;
         else        stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
   import gpio_amask_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  latch_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  ansel_q,
   output logic              slew_q
);
   logic hit_latch, hit_dir, hit_ansel, hit_slew;

   always_comb begin
      hit_latch = 1'b0;
      hit_dir   = 1'b0;
      hit_ansel = 1'b0;
      hit_slew  = 1'b0;
      if (wr) begin
         case (addr)
            REG_PORT, REG_LATCH: hit_latch = 1'b1;
            REG_DIR:             hit_dir   = 1'b1;
            REG_ANSEL:           hit_ansel = 1'b1;
            REG_SLEW:            hit_slew  = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '1;
         ansel_q <= '1;
         slew_q  <= 1'b1;
      end else begin
         if (hit_latch) latch_q <= wdata;
         if (hit_dir)   dir_q   <= wdata;
         if (hit_ansel) ansel_q <= wdata;
         if (hit_slew)  slew_q  <= wdata[0];
      end
   end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
   import gpio_amask_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  pin_sync,
   input  logic [WIDTH-1:0]  latch_q,
   input  logic [WIDTH-1:0]  dir_q,
   input  logic [WIDTH-1:0]  ansel_q,
   input  logic              slew_q,
   output logic [WIDTH-1:0]  rdata
);
   logic [WIDTH-1:0] pin_view;

   for (genvar i = 0; i < WIDTH; i++) begin : g_mask
      assign pin_view[i] = pin_sync[i] & ~ansel_q[i];
   end

   always_comb begin
      case (addr)
         REG_PORT:  rdata = pin_view;
         REG_LATCH: rdata = latch_q;
         REG_DIR:   rdata = dir_q;
         REG_ANSEL: rdata = ansel_q;
         REG_SLEW:  rdata = {{(WIDTH-1){1'b0}}, slew_q};
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_amask_port.sv
module gpio_amask_port
   import gpio_amask_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe,
   output logic              pad_slow
);
   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("gpio_amask_port: WIDTH must be 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_amask_port: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] pin_sync;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] ansel_q;
   logic             slew_q;

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pad_in),
      .q_sync  (pin_sync)
   );

   gpio_pin_regs #(.WIDTH(WIDTH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .latch_q (latch_q),
      .dir_q   (dir_q),
      .ansel_q (ansel_q),
      .slew_q  (slew_q)
   );

   gpio_rd_mux #(.WIDTH(WIDTH)) u_rd (
      .addr     (bus_addr),
      .pin_sync (pin_sync),
      .latch_q  (latch_q),
      .dir_q    (dir_q),
      .ansel_q  (ansel_q),
      .slew_q   (slew_q),
      .rdata    (bus_rdata)
   );

   assign pad_out  = latch_q;
   assign pad_oe   = ~dir_q;
   assign pad_slow = slew_q;
endmodule

// File: rtl/gpio_amask_port_chk.sv
module gpio_amask_port_chk
   import gpio_amask_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  pad_out,
   input logic [WIDTH-1:0]  pad_oe,
   input logic              pad_slow,
   input logic [WIDTH-1:0]  ansel_q
);
   // R1
   reset_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && pad_slow && ansel_q == '1));

   // R2
   analog_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 3'd0) |-> ((bus_rdata & ansel_q) == '0));

   // R4
   latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd1)) |=> (pad_out == $past(bus_wdata)));

   // R6
   ansel_keeps_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd3) |=> $stable(pad_out));

   // R7
   dir_drives_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd2) |=> (pad_oe == ~$past(bus_wdata)));

   // R8
   slew_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd4) |=> (pad_slow == $past(bus_wdata[0])));

   // R9
   unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr >= 3'd5) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_slow)));

   // R9
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr >= 3'd5) |-> (bus_rdata == '0));
endmodule

bind gpio_amask_port gpio_amask_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .pad_slow  (pad_slow),
   .ansel_q   (ansel_q)
);

// File: tb/gpio_amask_port_test.sv
`timescale 1ns/1ps
module gpio_amask_port_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic [2:0]   bus_addr = 3'd0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] pad_out;
   logic [W-1:0] pad_oe;
   logic         pad_slow;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   gpio_amask_port uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_slow(pad_slow)
   );

   // behavioural reference model
   int m_latch, m_dir, m_ansel, m_slew;
   int m_hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_latch = 0; m_dir = 255; m_ansel = 255; m_slew = 1;
         m_hist = '{0, 0};
      end else begin
         if (bus_wr) begin
            if (bus_addr == 0 || bus_addr == 1) m_latch = bus_wdata;
            else if (bus_addr == 2) m_dir = bus_wdata;
            else if (bus_addr == 3) m_ansel = bus_wdata;
            else if (bus_addr == 4) m_slew = bus_wdata % 2;
         end
         m_hist.push_front(int'(pad_in));
         void'(m_hist.pop_back());
      end
   end

   function automatic int model_read(int a);
      case (a)
         0: return m_hist[1] & (255 - m_ansel);
         1: return m_latch;
         2: return m_dir;
         3: return m_ansel;
         4: return m_slew;
         default: return 0;
      endcase
   endfunction

   task automatic check(string req, int act, int expv);
      n_checks++;
      if (act != expv) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, expv, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R6 pad_out", int'(pad_out), m_latch);
         check("R6 pad_oe", int'(pad_oe), 255 - m_dir);
         check("R8 pad_slow", int'(pad_slow), m_slew);
         case (bus_addr)
            3'd0: check("R2 port read", int'(bus_rdata), model_read(0));
            3'd1: check("R5 latch read", int'(bus_rdata), model_read(1));
            3'd2, 3'd3: check("R7 reg read", int'(bus_rdata), model_read(int'(bus_addr)));
            3'd4: check("R8 slew read", int'(bus_rdata), model_read(4));
            default: check("R9 unmapped read", int'(bus_rdata), 0);
         endcase
      end
   end

   task automatic bus_write(input logic [2:0] a, input logic [W-1:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [W-1:0] d);
      bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      @(posedge clk); #1;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [W-1:0] rd;
      pad_in = 8'hA5;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      check("R1 pad_oe", int'(pad_oe), 0);
      check("R1 pad_out", int'(pad_out), 0);
      check("R1 pad_slow", int'(pad_slow), 1);
      bus_read(3'd1, rd); check("R1 latch", int'(rd), 8'h00);
      bus_read(3'd2, rd); check("R1 dir", int'(rd), 8'hFF);
      bus_read(3'd3, rd); check("R1 ansel", int'(rd), 8'hFF);
      bus_read(3'd4, rd); check("R1 slew", int'(rd), 8'h01);
      settle();
      bus_read(3'd0, rd); check("R2 all analog", int'(rd), 8'h00);

      // R2 / R3 digital inputs
      bus_write(3'd3, 8'h00);
      settle();
      bus_read(3'd0, rd); check("R2 digital A5", int'(rd), 8'hA5);
      bus_addr = 3'd0; pad_in = 8'h5A;
      @(posedge clk); @(negedge clk);
      check("R3 one edge", int'(bus_rdata), 8'hA5);
      @(posedge clk); @(negedge clk);
      check("R3 two edges", int'(bus_rdata), 8'h5A);
      @(posedge clk); #1;

      // R2 split masks and walking ones
      bus_write(3'd3, 8'h0F);
      settle();
      bus_read(3'd0, rd); check("R2 mask low nibble", int'(rd), 8'h50);
      for (int i = 0; i < W; i++) begin
         pad_in = 8'(1 << i);
         settle();
         bus_read(3'd0, rd);
         check("R2 walking one", int'(rd), (i >= 4) ? (1 << i) : 0);
      end

      // R4 both write addresses reach the latch
      bus_write(3'd0, 8'h3C);
      bus_read(3'd1, rd); check("R4 port addr write", int'(rd), 8'h3C);
      check("R6 pad_out follows", int'(pad_out), 8'h3C);
      bus_write(3'd1, 8'hC3);
      bus_read(3'd1, rd); check("R4 latch addr write", int'(rd), 8'hC3);

      // R7 / R6 direction
      bus_write(3'd2, 8'h0F);
      check("R6 oe inverse", int'(pad_oe), 8'hF0);
      bus_read(3'd2, rd); check("R7 dir read", int'(rd), 8'h0F);

      // R6 / R5 analog select leaves outputs and latch read alone
      bus_write(3'd3, 8'hFF);
      check("R6 analog keeps out", int'(pad_out), 8'hC3);
      pad_in = 8'h00;
      settle();
      bus_read(3'd1, rd); check("R5 latch vs pins", int'(rd), 8'hC3);
      bus_read(3'd3, rd); check("R7 ansel read", int'(rd), 8'hFF);

      // R8 slew
      bus_write(3'd4, 8'h00);
      check("R8 slew cleared", int'(pad_slow), 0);
      bus_write(3'd4, 8'hFF);
      bus_read(3'd4, rd); check("R8 upper bits zero", int'(rd), 8'h01);
      bus_write(3'd4, 8'hFE);
      check("R8 bit0 only", int'(pad_slow), 0);

      // R9 unmapped addresses
      for (int a = 5; a < 8; a++) begin
         bus_write(3'(a), 8'h77);
         bus_read(3'(a), rd); check("R9 unmapped rd", int'(rd), 0);
      end
      bus_read(3'd1, rd); check("R9 latch kept", int'(rd), 8'hC3);
      bus_read(3'd2, rd); check("R9 dir kept", int'(rd), 8'h0F);
      bus_read(3'd3, rd); check("R9 ansel kept", int'(rd), 8'hFF);
      bus_read(3'd4, rd); check("R9 slew kept", int'(rd), 8'h00);

      // R10 read-modify-write hazard
      bus_write(3'd2, 8'h00);
      bus_write(3'd3, 8'hF0);
      bus_write(3'd1, 8'hF3);
      pad_in = 8'hF3;
      settle();
      bus_read(3'd0, rd); check("R10 port view", int'(rd), 8'h03);
      bus_write(3'd0, rd | 8'h04);
      bus_read(3'd1, rd); check("R10 latch after rmw", int'(rd), 8'h07);
      check("R10 pad_out after rmw", int'(pad_out), 8'h07);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule